// File: doc/BRIEF.md
# Synchronized Multi-Output Divider Bank

This block derives eight divided outputs from one fast input clock. Two programmable prescalers, A and B, each act as a clock-enable generator on the input clock. Each prescaler paces its own group of four integer output dividers. Group A holds outputs 0, 1, 4 and 5. Group B holds outputs 2, 3, 6 and 7. Every divided output is produced as a level on the input-clock domain, and it comes with an output-enable that stands in for the driver being turned on or left high-impedance.

An active-low, asynchronous sync input puts the bank into a quiet state. All output-enables drop, all outputs go low and every output divider is held at its start point. The prescalers are never stopped. On release, the sync level passes through a two-flop synchronizer. Each group then counts ten of its own prescaler ticks. On the tenth tick, all four outputs of that group turn on together and start from their low phase. Ratio changes are captured only while sync is held, so a running output never changes period mid-cycle. The two groups start in the same input-clock cycle only when their prescaler ratios are equal.

Top module: `clkdiv_bank`

## Requirements
- R1: While the synchronized sync level is low, and in reset, every bit of `outEn` and `clkOut` is 0. This holds from the third input-clock edge after `syncN` falls.
- R2: The prescalers keep counting while sync is held. For an unchanged ratio R, every group enable therefore rises in an input-clock cycle with the same residue modulo R, whatever the sync timing.
- R3: After `syncN` rises, a group's enable is first seen between 9R+3 and 10R+2 input-clock edges later, where R is that group's effective prescaler ratio. This covers the two synchronizer stages plus ten prescaler ticks.
- R4: Group A is outputs 0, 1, 4 and 5, paced by `preRatioA`. Group B is outputs 2, 3, 6 and 7, paced by `preRatioB`. All four enables of a group rise in the same cycle, which is a prescaler tick cycle.
- R5: For a divider ratio N of 2 or more, the output is low for floor(N/2) prescaler periods and high for N-floor(N/2) periods, repeating every N*R input cycles. It starts at the beginning of its low phase in the cycle its enable rises.
- R6: A divider ratio of 1 or 0 selects bypass. The output is then a one-input-cycle pulse on every prescaler tick, and the first pulse comes R-1 cycles after the enable rises.
- R7: Prescaler ratio fields are 4 bits wide. Values below 2 act as 2 and values above 8 act as 8.
- R8: If both prescaler ratios have been equal since reset, both groups raise their enables in the same input-clock cycle.
- R9: Changes to any ratio input while sync is released have no effect on the running outputs. They take effect at the next sync hold and release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncN | input | 1 | Asynchronous active-low sync |
| preRatioA | input | 4 | Prescaler A ratio (clamped to 2..8) |
| preRatioB | input | 4 | Prescaler B ratio (clamped to 2..8) |
| divRatio | input | 64 | Eight 8-bit divider ratios; output i uses bits [8i+7:8i] |
| clkOut | output | 8 | Divided outputs, forced low while disabled |
| outEn | output | 8 | Per-output enable |

## Verification
The hardest condition to reach from the ports is a ratio change that lands while a group is still counting its ten ticks or is already running. To reach it, the stimulus rewrites every ratio input a few cycles after release. It then compares the whole captured trace against the old settings, and it checks on the following sync that the new settings took hold. Prescaler free-running is only visible indirectly. Random hold lengths move the release across prescaler phases, and the residue of each enable cycle modulo R must not change.

// File: rtl/clkdiv_bank_pkg.sv
package clkdiv_bank_pkg;
  localparam int unsigned NUM_GRP = 2;

  // Strobes from control to datapath, one set per group
  typedef struct packed {
    logic holdDiv;  // keep group dividers at start point, outputs off
    logic loadCfg;  // capture ratio inputs into shadow registers
  } grpStrobe_t;

  // Output index bit 1 picks the group: 0,1,4,5 -> 0 and 2,3,6,7 -> 1
  function automatic int unsigned grpOf(input int unsigned idx);
    return (idx >> 1) & 1;
  endfunction
endpackage

// File: rtl/clkdiv_bank_presc.sv
module clkdiv_bank_presc #(
  parameter int unsigned PRE_W   = 4,
  parameter int unsigned PRE_MIN = 2,
  parameter int unsigned PRE_MAX = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadCfg,
  input  logic [PRE_W-1:0] ratioIn,
  output logic             tick
);
  logic [PRE_W-1:0] shadowR;
  logic [PRE_W-1:0] curR;
  logic [PRE_W-1:0] cnt;

  function automatic logic [PRE_W-1:0] clampR(input logic [PRE_W-1:0] r);
    if (r < PRE_W'(PRE_MIN)) return PRE_W'(PRE_MIN);
    if (r > PRE_W'(PRE_MAX)) return PRE_W'(PRE_MAX);
    return r;
  endfunction

  assign tick = (cnt == curR - PRE_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowR <= PRE_W'(PRE_MIN);
      curR    <= PRE_W'(PRE_MIN);
      cnt     <= '0;
    end else begin
      if (loadCfg) shadowR <= clampR(ratioIn);
      if (tick) begin
        cnt  <= '0;
        curR <= shadowR;  // new ratio only at a period boundary
      end else begin
        cnt <= cnt + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/clkdiv_bank_outdiv.sv
module clkdiv_bank_outdiv #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             holdDiv,
  input  logic             loadCfg,
  input  logic [DIV_W-1:0] ratioIn,
  output logic             divOut
);
  logic [DIV_W-1:0] shadowN;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] halfN;
  logic             isBypass;

  assign halfN    = shadowN >> 1;
  assign isBypass = (shadowN == DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowN <= DIV_W'(1);
      cnt     <= '0;
    end else begin
      if (loadCfg) shadowN <= (ratioIn == '0) ? DIV_W'(1) : ratioIn;
      if (holdDiv)
        cnt <= '0;
      else if (tick)
        cnt <= (cnt == shadowN - DIV_W'(1)) ? '0 : cnt + DIV_W'(1);
    end
  end

  always_comb begin
    if (holdDiv)       divOut = 1'b0;
    else if (isBypass) divOut = tick;
    else               divOut = (cnt >= halfN);
  end
endmodule

// File: rtl/clkdiv_bank_ctrl.sv
module clkdiv_bank_ctrl
  import clkdiv_bank_pkg::*;
#(
  parameter int unsigned WAIT_TICKS = 10
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           syncN,
  input  logic [NUM_GRP-1:0]             grpTick,
  output logic                           syncSafe,
  output grpStrobe_t [NUM_GRP-1:0]       strobe
);
  localparam int unsigned WAIT_W = $clog2(WAIT_TICKS + 1);

  logic syncMeta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncMeta <= 1'b0;
      syncSafe <= 1'b0;
    end else begin
      syncMeta <= syncN;
      syncSafe <= syncMeta;
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : gGrp
    logic [WAIT_W-1:0] waitCnt;
    logic              grpEn;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        waitCnt <= '0;
        grpEn   <= 1'b0;
      end else if (!syncSafe) begin
        waitCnt <= '0;
        grpEn   <= 1'b0;
      end else if (!grpEn && grpTick[g]) begin
        if (waitCnt == WAIT_W'(WAIT_TICKS - 1)) grpEn <= 1'b1;
        else                                     waitCnt <= waitCnt + WAIT_W'(1);
      end
    end

    assign strobe[g].holdDiv = ~grpEn;
    assign strobe[g].loadCfg = ~syncSafe;
  end
endmodule

// File: rtl/clkdiv_bank_dp.sv
module clkdiv_bank_dp
  import clkdiv_bank_pkg::*;
#(
  parameter int unsigned NUM_OUT = 8,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned PRE_W   = 4,
  parameter int unsigned PRE_MIN = 2,
  parameter int unsigned PRE_MAX = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  grpStrobe_t [NUM_GRP-1:0] strobe,
  input  logic [PRE_W-1:0]         preRatioA,
  input  logic [PRE_W-1:0]         preRatioB,
  input  logic [NUM_OUT*DIV_W-1:0] divRatio,
  output logic [NUM_GRP-1:0]       grpTick,
  output logic [NUM_OUT-1:0]       clkOut,
  output logic [NUM_OUT-1:0]       outEn
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : gPre
    clkdiv_bank_presc #(
      .PRE_W(PRE_W), .PRE_MIN(PRE_MIN), .PRE_MAX(PRE_MAX)
    ) presc_i (
      .clk    (clk),
      .rstN   (rstN),
      .loadCfg(strobe[g].loadCfg),
      .ratioIn((g == 0) ? preRatioA : preRatioB),
      .tick   (grpTick[g])
    );
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : gOut
    localparam int unsigned G = grpOf(i);

    clkdiv_bank_outdiv #(.DIV_W(DIV_W)) div_i (
      .clk    (clk),
      .rstN   (rstN),
      .tick   (grpTick[G]),
      .holdDiv(strobe[G].holdDiv),
      .loadCfg(strobe[G].loadCfg),
      .ratioIn(divRatio[i*DIV_W +: DIV_W]),
      .divOut (clkOut[i])
    );

    assign outEn[i] = ~strobe[G].holdDiv;
  end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_bank_pkg::*;
#(
  parameter int unsigned NUM_OUT    = 8,
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned PRE_W      = 4,
  parameter int unsigned PRE_MIN    = 2,
  parameter int unsigned PRE_MAX    = 8,
  parameter int unsigned WAIT_TICKS = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     syncN,
  input  logic [PRE_W-1:0]         preRatioA,
  input  logic [PRE_W-1:0]         preRatioB,
  input  logic [NUM_OUT*DIV_W-1:0] divRatio,
  output logic [NUM_OUT-1:0]       clkOut,
  output logic [NUM_OUT-1:0]       outEn
);
  logic                     syncSafe;
  logic [NUM_GRP-1:0]       grpTick;
  grpStrobe_t [NUM_GRP-1:0] strobe;

  clkdiv_bank_ctrl #(.WAIT_TICKS(WAIT_TICKS)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .syncN   (syncN),
    .grpTick (grpTick),
    .syncSafe(syncSafe),
    .strobe  (strobe)
  );

  clkdiv_bank_dp #(
    .NUM_OUT(NUM_OUT), .DIV_W(DIV_W), .PRE_W(PRE_W),
    .PRE_MIN(PRE_MIN), .PRE_MAX(PRE_MAX)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .preRatioA(preRatioA),
    .preRatioB(preRatioB),
    .divRatio (divRatio),
    .grpTick  (grpTick),
    .clkOut   (clkOut),
    .outEn    (outEn)
  );
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk
  import clkdiv_bank_pkg::*;
#(
  parameter int unsigned NUM_OUT = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               syncSafe,
  input logic [NUM_GRP-1:0] grpTick,
  input logic [NUM_OUT-1:0] outEn,
  input logic [NUM_OUT-1:0] clkOut
);
  AST_QUIET_IN_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    !syncSafe |=> (outEn == '0 && clkOut == '0)); // R1

  AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (clkOut & ~outEn) == '0); // R1

  for (genvar i = 0; i < NUM_OUT; i++) begin : gOutChk
    localparam int unsigned G = grpOf(i);

    AST_EN_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
      $rose(outEn[i]) |-> $past(grpTick[G])); // R4

    AST_EN_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(outEn[i]) |-> $past(syncSafe)); // R3

    AST_LOW_AT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
      $rose(outEn[i]) |-> !clkOut[i]); // R5
  end
endmodule

bind clkdiv_bank clkdiv_bank_chk #(.NUM_OUT(NUM_OUT)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .syncSafe(syncSafe),
  .grpTick (grpTick),
  .outEn   (outEn),
  .clkOut  (clkOut)
);

// File: tb/clkdiv_bank_tb_top.sv
module clkdiv_bank_tb_top;
  localparam int NO  = 8;
  localparam int DW  = 8;
  localparam int PW  = 4;
  localparam int TRL = 320;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            syncN = 1'b0;
  logic [PW-1:0]   preA = '0;
  logic [PW-1:0]   preB = '0;
  logic [NO*DW-1:0] divR = '0;
  logic [NO-1:0]   clkOut;
  logic [NO-1:0]   outEn;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int prevRes [2] = '{-1, -1};
  int prevR   [2] = '{-1, -1};
  logic [NO-1:0] trOut [TRL];
  logic [NO-1:0] trEn  [TRL];

  always #4 clk = ~clk;  // 125 MHz

  clkdiv_bank dut_i (
    .clk(clk), .rstN(rstN), .syncN(syncN),
    .preRatioA(preA), .preRatioB(preB), .divRatio(divR),
    .clkOut(clkOut), .outEn(outEn)
  );

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int effR(input int r);
    if (r < 2) return 2;
    if (r > 8) return 8;
    return r;
  endfunction

  function automatic int effN(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  function automatic bit expOut(input int t, input int n, input int r);
    if (t < 0) return 1'b0;
    if (n == 1) return (t % r) == r - 1;
    return ((t / r) % n) >= (n / 2);
  endfunction

  function automatic int grpOfIdx(input int i);
    return (i >> 1) & 1;
  endfunction

  task automatic randCfg();
    preA = PW'($urandom % 16);
    preB = PW'($urandom % 16);
    for (int i = 0; i < NO; i++) divR[i*DW +: DW] = DW'($urandom % 13);
  endtask

  task automatic runSync(input int holdCyc, input bit changeCfg, input bit expectAlign);
    int cfgR [2];
    int cfgN [NO];
    int enIdx [2];
    int relCyc;
    bit quiet;
    quiet = 1'b1;
    syncN = 1'b0;
    for (int k = 0; k < holdCyc; k++) begin
      step();
      if (k >= 3 && (outEn != '0 || clkOut != '0)) quiet = 1'b0;
    end
    chk(quiet, "R1", "outputs not quiet during sync hold", int'(outEn), 0);

    cfgR[0] = effR(int'(preA));
    cfgR[1] = effR(int'(preB));
    for (int i = 0; i < NO; i++) cfgN[i] = effN(int'(divR[i*DW +: DW]));

    syncN = 1'b1;
    relCyc = cyc;
    for (int k = 0; k < TRL; k++) begin
      step();
      trOut[k] = clkOut;
      trEn[k]  = outEn;
      if (k == 5 && changeCfg) randCfg();  // R9: must not disturb this run
    end

    for (int g = 0; g < 2; g++) begin
      int lead;
      int lo;
      int hi;
      int res;
      lead = (g == 0) ? 0 : 2;
      enIdx[g] = -1;
      for (int k = 0; k < TRL; k++)
        if (enIdx[g] < 0 && trEn[k][lead]) enIdx[g] = k;
      lo = 9 * cfgR[g] + 2;
      hi = 10 * cfgR[g] + 1;
      chk(enIdx[g] >= lo && enIdx[g] <= hi, "R3", "release latency",
          enIdx[g], lo);
      // R4: all members of the group enable in the same sample
      for (int i = 0; i < NO; i++) begin
        if (grpOfIdx(i) == g) begin
          int first;
          first = -1;
          for (int k = 0; k < TRL; k++)
            if (first < 0 && trEn[k][i]) first = k;
          chk(first == enIdx[g], "R4", $sformatf("group enable of output %0d", i),
              first, enIdx[g]);
        end
      end
      res = (relCyc + enIdx[g]) % cfgR[g];
      if (prevR[g] == cfgR[g] && prevRes[g] >= 0)
        chk(res == prevRes[g], "R2", "prescaler phase moved across sync", res, prevRes[g]);
      prevRes[g] = res;
      prevR[g]   = cfgR[g];
    end

    if (expectAlign)
      chk(enIdx[0] == enIdx[1], "R8", "groups not aligned with equal ratios",
          enIdx[1], enIdx[0]);

    for (int i = 0; i < NO; i++) begin
      int g;
      int bad;
      int badK;
      g = grpOfIdx(i);
      bad = 0;
      badK = -1;
      for (int k = 0; k < TRL; k++) begin
        bit e;
        e = expOut(k - enIdx[g], cfgN[i], cfgR[g]);
        if (trOut[k][i] !== e) begin
          bad++;
          if (badK < 0) badK = k;
        end
      end
      chk(bad == 0,
          changeCfg ? "R9" : ((cfgN[i] == 1) ? "R6" : "R5"),
          $sformatf("waveform out%0d N=%0d R=%0d first bad sample %0d", i,
                    cfgN[i], cfgR[g], badK),
          bad, 0);
    end
  endtask

  initial begin
    bit rstQuiet;
    void'($urandom(32'h5eed1234));
    preA = 4'd4;
    preB = 4'd4;
    for (int i = 0; i < NO; i++) divR[i*DW +: DW] = DW'(i + 1);
    rstQuiet = 1'b1;
    for (int k = 0; k < 6; k++) begin
      step();
      if (outEn != '0 || clkOut != '0) rstQuiet = 1'b0;
    end
    chk(rstQuiet, "R1", "outputs not quiet in reset", int'(clkOut), 0);
    rstN = 1'b1;

    // Equal ratios since reset: groups must align (R8), phase steady (R2)
    runSync(20, 1'b0, 1'b1);
    runSync(23, 1'b0, 1'b1);
    runSync(27, 1'b0, 1'b1);
    preA = 4'd8;
    preB = 4'd8;
    divR = {8'd200, 8'd0, 8'd9, 8'd1, 8'd2, 8'd3, 8'd4, 8'd5};
    runSync(21, 1'b0, 1'b1);

    // R7 clamp corners
    preA = 4'd0;
    preB = 4'd15;
    divR = {8'd2, 8'd3, 8'd1, 8'd6, 8'd7, 8'd0, 8'd12, 8'd11};
    runSync(24, 1'b0, 1'b0);
    preA = 4'd1;
    preB = 4'd9;
    runSync(22, 1'b0, 1'b0);
    runSync(31, 1'b0, 1'b0);

    // R9 directed: change everything after release
    runSync(20, 1'b1, 1'b0);
    runSync(25, 1'b0, 1'b0);

    // Constrained random mix
    for (int it = 0; it < 24; it++) begin
      if ($urandom % 3 == 0) randCfg();
      runSync(20 + int'($urandom % 17), ($urandom % 4) == 0, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule